// File: doc/BRIEF.md
# Egress Shim Stripper and VC Mapper

This block sits at the egress side of a router port and takes in a stream of 32-bit packet words from the switch fabric. Each packet starts with a two-word internal header (8 bytes) that the ingress side put in front of the IP datagram. The block reads the outbound interface number from that header and keeps only its sub-port field. It turns the sub-port into the outgoing link virtual circuit number, removes the two header words, and forwards the rest of the packet. The packet length it reports is 8 bytes shorter, so that the downstream framing trailer can be rewritten.

Packets whose sub-port lies outside the supported range are discarded whole and counted. Fragments too short to hold a header plus at least one payload word are also discarded. Both streams use a valid/ready handshake with start and end markers. The circuit number and length outputs go with the forwarded words of each packet.

Top module: `egs_shim_strip`

## Requirements
- R1: After reset, out_valid is 0, err_count is 0 and in_ready is 1.
- R2: The word accepted with in_sop and the word after it are never forwarded. Every later word of the packet is forwarded unchanged and in order. out_sop is 1 only on the first forwarded word, and out_eop is 1 on the word that arrived with in_eop.
- R3: out_vc equals 128 plus the sub-port. The sub-port is bits 5:0 of the second header word, which carries the outbound interface number in bits 15:0 and has the port number in bits 15:6.
- R4: A packet whose sub-port is greater than 15 produces no output word.
- R5: err_count goes up by one for each accepted second header word whose sub-port is greater than 15. It stays at 2^ERR_W-1 once it reaches that value.
- R6: out_len equals in_len minus 8, where in_len is sampled with the in_sop word. If in_len is below 8, out_len is 0.
- R7: out_vc and out_len are valid with the first forwarded word and do not change until the end-of-packet word has been forwarded.
- R8: A packet that ends on its first or second word produces no output. The block then accepts the next start marker as a new packet.
- R9: Words that arrive outside a packet (no in_sop while idle) are accepted and discarded, with no output.
- R10: While a payload word is offered and out_ready is 0, in_ready is 0 and the offered word stays on out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept the input word |
| in_data | input | DATA_W | Input word |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_len | input | LEN_W | Incoming packet byte length, sampled with the first word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the output word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First forwarded word of a packet |
| out_eop | output | 1 | Last forwarded word of a packet |
| out_vc | output | VC_W | Outbound virtual circuit for the current packet |
| out_len | output | LEN_W | Byte length with the header removed |
| err_count | output | ERR_W | Saturating count of bad sub-ports |

## Verification
The assertions check on every cycle that no forwarded word carries a circuit number outside 128 to 143. They also check that circuit number and length hold steady across a packet, that a start marker is never repeated within a packet, that an invalid sub-port or a one-word fragment is followed by silence on the output, that the error counter never advances by more than one, and that back-pressure reaches the input. Only the bench scenarios can show that exactly the two header words are removed, that payload words keep their order and contents, and that the length is reduced by 8 with a floor of zero. The same holds for idle stray words being swallowed, two-word fragments being dropped, and the counter saturating after hundreds of bad packets.

// File: rtl/egs_pkg.sv
package egs_pkg;

  localparam int unsigned SHIM_BYTES = 8;
  localparam int unsigned VC_BASE    = 128;
  localparam int unsigned SPI_MAX    = 15;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SHIM = 2'd1,
    ST_FWD  = 2'd2,
    ST_DROP = 2'd3
  } egs_state_e;

  function automatic logic spi_ok(input int unsigned spi);
    return spi <= SPI_MAX;
  endfunction

  function automatic int unsigned vc_of(input int unsigned spi);
    return VC_BASE + spi;
  endfunction

  function automatic int unsigned strip_len(input int unsigned len);
    if (len < SHIM_BYTES) return 0;
    return len - SHIM_BYTES;
  endfunction

endpackage

// File: rtl/egs_ctrl.sv
module egs_ctrl
  import egs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sop,
  input  logic in_eop,
  input  logic out_ready,
  input  logic spi_good,
  output logic in_ready,
  output logic fwd_valid,
  output logic fwd_first,
  output logic len_load,
  output logic vc_load,
  output logic err_inc,
  output logic st_idle,
  output logic st_fwd
);

  egs_state_e state_q, state_d;
  logic       first_q;
  logic       acc;

  assign acc = in_valid & in_ready;

  always_comb begin
    state_d   = state_q;
    in_ready  = 1'b1;
    fwd_valid = 1'b0;
    len_load  = 1'b0;
    vc_load   = 1'b0;
    err_inc   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (acc && in_sop) begin
          len_load = 1'b1;
          if (!in_eop) state_d = ST_SHIM;
        end
      end
      ST_SHIM: begin
        if (acc) begin
          err_inc = !spi_good;
          if (in_eop) begin
            state_d = ST_IDLE;
          end else if (!spi_good) begin
            state_d = ST_DROP;
          end else begin
            vc_load = 1'b1;
            state_d = ST_FWD;
          end
        end
      end
      ST_FWD: begin
        in_ready  = out_ready;
        fwd_valid = in_valid;
        if (acc && in_eop) state_d = ST_IDLE;
      end
      ST_DROP: begin
        if (acc && in_eop) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (vc_load) first_q <= 1'b1;
      else if (acc && state_q == ST_FWD) first_q <= 1'b0;
    end
  end

  assign fwd_first = first_q;
  assign st_idle   = (state_q == ST_IDLE);
  assign st_fwd    = (state_q == ST_FWD);

endmodule

// File: rtl/egs_hdr.sv
module egs_hdr
  import egs_pkg::*;
#(
  parameter int SPI_W = 6,
  parameter int VC_W  = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_load,
  input  logic             vc_load,
  input  logic [LEN_W-1:0] in_len,
  input  logic [SPI_W-1:0] spi,
  output logic             spi_good,
  output logic [VC_W-1:0]  vc_q,
  output logic [LEN_W-1:0] len_q
);

  assign spi_good = spi_ok(32'(spi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_q  <= '0;
      len_q <= '0;
    end else begin
      if (len_load) len_q <= LEN_W'(strip_len(32'(in_len)));
      if (vc_load)  vc_q  <= VC_W'(vc_of(32'(spi)));
    end
  end

endmodule

// File: rtl/egs_errcnt.sv
module egs_errcnt #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_inc,
  output logic [ERR_W-1:0] count
);

  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (err_inc && count != CNT_MAX) count <= count + 1'b1;
  end

endmodule

// File: rtl/egs_shim_strip.sv
module egs_shim_strip #(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int VC_W    = 16,
  parameter int ERR_W   = 8,
  parameter int SPI_LSB = 0,
  parameter int SPI_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [VC_W-1:0]   out_vc,
  output logic [LEN_W-1:0]  out_len,
  output logic [ERR_W-1:0]  err_count
);

  logic             spi_good;
  logic             fwd_valid;
  logic             fwd_first;
  logic             len_load;
  logic             vc_load;
  logic             err_inc;
  logic             st_idle;
  logic             st_fwd;
  logic [SPI_W-1:0] spi;

  assign spi = in_data[SPI_LSB +: SPI_W];

  egs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_ready (out_ready),
    .spi_good  (spi_good),
    .in_ready  (in_ready),
    .fwd_valid (fwd_valid),
    .fwd_first (fwd_first),
    .len_load  (len_load),
    .vc_load   (vc_load),
    .err_inc   (err_inc),
    .st_idle   (st_idle),
    .st_fwd    (st_fwd)
  );

  egs_hdr #(
    .SPI_W (SPI_W),
    .VC_W  (VC_W),
    .LEN_W (LEN_W)
  ) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_load (len_load),
    .vc_load  (vc_load),
    .in_len   (in_len),
    .spi      (spi),
    .spi_good (spi_good),
    .vc_q     (out_vc),
    .len_q    (out_len)
  );

  egs_errcnt #(
    .ERR_W (ERR_W)
  ) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_inc (err_inc),
    .count   (err_count)
  );

  assign out_valid = fwd_valid;
  assign out_data  = in_data;
  assign out_sop   = st_fwd & fwd_first;
  assign out_eop   = st_fwd & in_eop;

endmodule

// File: rtl/egs_shim_strip_chk.sv
module egs_shim_strip_chk #(
  parameter int VC_W  = 16,
  parameter int LEN_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sop,
  input logic             in_eop,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_sop,
  input logic             out_eop,
  input logic [VC_W-1:0]  out_vc,
  input logic [LEN_W-1:0] out_len,
  input logic [ERR_W-1:0] err_count,
  input logic             err_inc,
  input logic             st_idle
);

  p_vc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vc >= VC_W'(128) && out_vc <= VC_W'(143)));

  p_bad_spi_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_inc |=> !out_valid);

  p_err_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_count - $past(err_count)) <= ERR_W'(1)));

  p_hdr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eop) |=> ($stable(out_vc) && $stable(out_len)));

  p_sop_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_sop) |=> !out_sop);

  p_short_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && in_valid && in_ready && in_sop && in_eop) |=> !out_valid);

  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind egs_shim_strip egs_shim_strip_chk #(
  .VC_W  (VC_W),
  .LEN_W (LEN_W),
  .ERR_W (ERR_W)
) u_chk (.*);

// File: tb/tb_egs_shim_strip.sv
module tb_egs_shim_strip;

  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam int VC_W   = 16;
  localparam int ERR_W  = 8;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_sop = 1'b0;
  logic              in_eop = 1'b0;
  logic [LEN_W-1:0]  in_len = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;
  logic              out_sop;
  logic              out_eop;
  logic [VC_W-1:0]   out_vc;
  logic [LEN_W-1:0]  out_len;
  logic [ERR_W-1:0]  err_count;

  always #4 clk = ~clk;

  egs_shim_strip dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_eop, .in_len,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop, .out_vc, .out_len,
    .err_count
  );

  typedef struct packed {
    logic [5:0]  spi;
    logic [15:0] len;
    logic [7:0]  total;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{spi: 6'd0,  len: 16'd100,  total: 8'd3},
    '{spi: 6'd15, len: 16'd40,   total: 8'd5},
    '{spi: 6'd7,  len: 16'd8,    total: 8'd4},
    '{spi: 6'd3,  len: 16'd5,    total: 8'd3},
    '{spi: 6'd16, len: 16'd60,   total: 8'd4},
    '{spi: 6'd63, len: 16'd20,   total: 8'd3},
    '{spi: 6'd9,  len: 16'd1500, total: 8'd10}
  };

  int n_checks = 0;
  int n_fail   = 0;
  int exp_err  = 0;
  int pkt_id   = 0;
  bit done     = 0;

  logic [DATA_W-1:0] mon_data [64];
  int          mon_cnt = 0;
  int          mon_bad = 0;
  int          mon_eop_idx = -1;
  logic        mon_sop0 = 1'b0;
  logic [VC_W-1:0]  mon_vc = '0;
  logic [LEN_W-1:0] mon_len = '0;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (mon_cnt < 64) mon_data[mon_cnt] = out_data;
      if (mon_cnt == 0) begin
        mon_vc   = out_vc;
        mon_len  = out_len;
        mon_sop0 = out_sop;
      end else begin
        if (out_sop) mon_bad++;
        if (out_vc != mon_vc || out_len != mon_len) mon_bad++;
      end
      if (out_eop) mon_eop_idx = mon_cnt;
      mon_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pay_word(input int id, input int k);
    return {8'hD0, 8'(id), 16'(k)};
  endfunction

  task automatic send_word(input logic [31:0] d, input logic s, input logic e,
                           input logic [15:0] l);
    in_valid = 1'b1;
    in_data  = d;
    in_sop   = s;
    in_eop   = e;
    in_len   = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic send_pkt(input logic [5:0] spi, input logic [15:0] len, input int total);
    pkt_id++;
    send_word({16'hC0DE, 16'h0000}, 1'b1, total == 1, len);
    if (total >= 2)
      send_word({16'h1234, 10'h2A5, spi}, 1'b0, total == 2, 16'h0);
    for (int k = 0; k < total - 2; k++)
      send_word(pay_word(pkt_id, k), 1'b0, k == total - 3, 16'h0);
  endtask

  task automatic mon_clear();
    mon_cnt = 0;
    mon_bad = 0;
    mon_eop_idx = -1;
    mon_sop0 = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic check_pkt(input logic [5:0] spi, input logic [15:0] len, input int total);
    bit good;
    int elen;
    good = (spi <= 6'd15) && (total >= 3);
    elen = (int'(len) >= 8) ? int'(len) - 8 : 0;
    if (spi > 6'd15 && total >= 2) exp_err = (exp_err < ERR_MAX) ? exp_err + 1 : ERR_MAX;
    if (good) begin
      chk(mon_cnt == total - 2, "R2 forwarded word count", mon_cnt, total - 2);
      chk(mon_data[0] == pay_word(pkt_id, 0), "R2 first forwarded word",
          int'(mon_data[0]), int'(pay_word(pkt_id, 0)));
      chk(mon_data[total-3] == pay_word(pkt_id, total - 3), "R2 last forwarded word",
          int'(mon_data[total-3]), int'(pay_word(pkt_id, total - 3)));
      chk(mon_sop0 == 1'b1, "R2 out_sop on first word", int'(mon_sop0), 1);
      chk(mon_eop_idx == total - 3, "R2 out_eop position", mon_eop_idx, total - 3);
      chk(int'(mon_vc) == 128 + int'(spi), "R3 out_vc", int'(mon_vc), 128 + int'(spi));
      chk(int'(mon_len) == elen, "R6 out_len", int'(mon_len), elen);
      chk(mon_bad == 0, "R7 vc/len stable, single sop", mon_bad, 0);
    end else if (total >= 3) begin
      chk(mon_cnt == 0, "R4 bad sub-port packet dropped", mon_cnt, 0);
    end else begin
      chk(mon_cnt == 0, "R8 short packet dropped", mon_cnt, 0);
    end
    chk(int'(err_count) == exp_err, "R5 err_count", int'(err_count), exp_err);
  endtask

  task automatic run_pkt(input logic [5:0] spi, input logic [15:0] len, input int total);
    mon_clear();
    send_pkt(spi, len, total);
    settle();
    check_pkt(spi, len, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(int'(err_count) == 0, "R1 reset err_count", int'(err_count), 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    @(posedge clk);
    #1;

    for (int i = 0; i < 7; i++)
      run_pkt(VECS[i].spi, VECS[i].len, int'(VECS[i].total));

    // R8: fragment ending on first word, then one ending on second word
    run_pkt(6'd4, 16'd30, 1);
    run_pkt(6'd4, 16'd30, 2);
    run_pkt(6'd20, 16'd30, 2);
    run_pkt(6'd5, 16'd33, 3);

    // R9: stray words while idle
    mon_clear();
    send_word(32'hDEAD0001, 1'b0, 1'b0, 16'd0);
    send_word(32'hDEAD0002, 1'b0, 1'b1, 16'd0);
    settle();
    chk(mon_cnt == 0, "R9 stray idle words dropped", mon_cnt, 0);
    run_pkt(6'd11, 16'd64, 4);

    // R10: back-pressure while forwarding
    mon_clear();
    out_ready = 1'b0;
    fork
      send_pkt(6'd2, 16'd50, 5);
      begin
        repeat (6) @(posedge clk);
        #2;
        chk(in_ready == 1'b0, "R10 in_ready low under back-pressure", int'(in_ready), 0);
        chk(out_valid == 1'b1, "R10 word offered under back-pressure", int'(out_valid), 1);
        chk(out_data == pay_word(pkt_id, 0), "R10 offered word held",
            int'(out_data), int'(pay_word(pkt_id, 0)));
        out_ready = 1'b1;
      end
    join
    settle();
    check_pkt(6'd2, 16'd50, 5);

    // R5: saturation of the error counter
    while (exp_err < ERR_MAX) begin
      send_pkt(6'd40, 16'd20, 3);
      exp_err++;
    end
    send_pkt(6'd40, 16'd20, 3);
    send_pkt(6'd40, 16'd20, 3);
    settle();
    chk(int'(err_count) == ERR_MAX, "R5 err_count saturates", int'(err_count), ERR_MAX);

    run_pkt(6'd1, 16'd12, 3);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule